// File: doc/BRIEF.md
# Staged Switch Operand Loader

This block gathers the inputs of a two-operand floating-point arithmetic unit from a single 16-bit bank of switches. The switch bank is far narrower than what the unit needs: two 32-bit single-precision operands and a 2-bit operation code. The loader therefore reuses the bank over five fixed stages. Each stage captures one field on one debounced button press. The stages run in a fixed order: upper half of operand A, lower half of operand A, the operation code, upper half of operand B, and lower half of operand B.

Every captured value also appears as a 16-bit word that a seven-segment driver shows in hex. This word updates on the same clock edge that stores the field. After the fifth capture the loader enters a hold state. In that state it raises a done flag and keeps both operands and the opcode frozen for the downstream arithmetic unit. Only reset leaves the hold state.

The button input is a debounced level. The loader detects its rising edge itself, so a button held down through many cycles counts as exactly one press.

Top module: `stage_loader`

## Requirements
- R1: Successive presses store the switch word into, in order: opnd_a[31:16], opnd_a[15:0], opcode, opnd_b[31:16] and opnd_b[15:0].
- R2: On the clock edge that stores a field, hex_word takes the captured value. For the opcode stage that value is sw[1:0] zero-extended to 16 bits.
- R3: The opcode stage stores only sw[1:0] and ignores sw[15:2]. The codes are 00 add, 01 subtract, 10 multiply and 11 divide.
- R4: A press is a 0-to-1 transition of btn seen at a clock edge. Holding btn high does not advance further, and a release followed by another rise counts as the next press.
- R5: done is low during all load stages. It goes high on the clock edge of the fifth capture and is high only in the hold state.
- R6: In the hold state, presses and switch changes leave opnd_a, opnd_b, opcode and hex_word unchanged, and done stays high.
- R7: Synchronous active-low reset clears opnd_a, opnd_b, opcode, hex_word and done, and returns the loader to the first stage. This applies even in the middle of a load sequence.
- R8: Without a press, switch changes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw | input | 16 | Switch bank |
| btn | input | 1 | Debounced load button level |
| opnd_a | output | 32 | Assembled operand A |
| opnd_b | output | 32 | Assembled operand B |
| opcode | output | 2 | Operation code |
| hex_word | output | 16 | Most recently captured word, for hex readout |
| done | output | 1 | High in the terminal hold state |

## Verification
A wrong stage value shows at the very next press, when the switch word lands in the wrong half of an operand, in the opcode, or nowhere. hex_word exposes the error on that same edge. A faulty edge detector shows a cycle after a held press, as an extra stage advance that corrupts the following field or raises done too early. A hold state that leaks presses shows at the first press after done rises, as a changed operand or hex_word.

// File: rtl/stage_loader_pkg.sv
package stage_loader_pkg;

    typedef enum logic [2:0] {
        ST_A_HI  = 3'd0,
        ST_A_LO  = 3'd1,
        ST_OPC   = 3'd2,
        ST_B_HI  = 3'd3,
        ST_B_LO  = 3'd4,
        ST_HOLD  = 3'd5
    } stage_e;

    typedef struct packed {
        stage_e stage;
        logic   btn_seen;
    } seq_state_t;

endpackage

// File: rtl/stage_loader_seq.sv
module stage_loader_seq
    import stage_loader_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   btn,
    output logic   press,
    output stage_e stage,
    output logic   done
);

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.btn_seen = btn;
        press          = btn & ~seq_q.btn_seen;
        if (press) begin
            unique case (seq_q.stage)
                ST_A_HI: seq_d.stage = ST_A_LO;
                ST_A_LO: seq_d.stage = ST_OPC;
                ST_OPC:  seq_d.stage = ST_B_HI;
                ST_B_HI: seq_d.stage = ST_B_LO;
                ST_B_LO: seq_d.stage = ST_HOLD;
                default: seq_d.stage = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.stage    <= ST_A_HI;
            seq_q.btn_seen <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stage = seq_q.stage;
    assign done  = (seq_q.stage == ST_HOLD);

endmodule

// File: rtl/stage_loader_fields.sv
module stage_loader_fields
    import stage_loader_pkg::*;
#(
    parameter int SW_W = 16,
    parameter int OP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              press,
    input  stage_e            stage,
    input  logic [SW_W-1:0]   sw,
    output logic [2*SW_W-1:0] opnd_a,
    output logic [2*SW_W-1:0] opnd_b,
    output logic [OP_W-1:0]   opcode,
    output logic [SW_W-1:0]   hex_word
);

    localparam int OPND_W = 2 * SW_W;

    typedef struct packed {
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
        logic [OP_W-1:0]   op;
        logic [SW_W-1:0]   word;
    } field_t;

    field_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (press) begin
            unique case (stage)
                ST_A_HI: begin
                    fld_d.a[OPND_W-1:SW_W] = sw;
                    fld_d.word             = sw;
                end
                ST_A_LO: begin
                    fld_d.a[SW_W-1:0] = sw;
                    fld_d.word        = sw;
                end
                ST_OPC: begin
                    fld_d.op   = sw[OP_W-1:0];
                    fld_d.word = {{(SW_W-OP_W){1'b0}}, sw[OP_W-1:0]};
                end
                ST_B_HI: begin
                    fld_d.b[OPND_W-1:SW_W] = sw;
                    fld_d.word             = sw;
                end
                ST_B_LO: begin
                    fld_d.b[SW_W-1:0] = sw;
                    fld_d.word        = sw;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign opnd_a   = fld_q.a;
    assign opnd_b   = fld_q.b;
    assign opcode   = fld_q.op;
    assign hex_word = fld_q.word;

endmodule

// File: rtl/stage_loader.sv
module stage_loader
    import stage_loader_pkg::*;
#(
    parameter int SW_W = 16,
    parameter int OP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   sw,
    input  logic              btn,
    output logic [2*SW_W-1:0] opnd_a,
    output logic [2*SW_W-1:0] opnd_b,
    output logic [OP_W-1:0]   opcode,
    output logic [SW_W-1:0]   hex_word,
    output logic              done
);

    logic   press;
    stage_e stage;

    stage_loader_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn),
        .press (press),
        .stage (stage),
        .done  (done)
    );

    stage_loader_fields #(
        .SW_W (SW_W),
        .OP_W (OP_W)
    ) u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .press    (press),
        .stage    (stage),
        .sw       (sw),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .opcode   (opcode),
        .hex_word (hex_word)
    );

endmodule

// File: rtl/stage_loader_chk.sv
module stage_loader_chk #(
    parameter int SW_W = 16,
    parameter int OP_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              press,
    input logic              done,
    input logic [2*SW_W-1:0] opnd_a,
    input logic [2*SW_W-1:0] opnd_b,
    input logic [OP_W-1:0]   opcode,
    input logic [SW_W-1:0]   hex_word
);

    // R8
    idle_outputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !press |=> ($stable(opnd_a) && $stable(opnd_b) && $stable(opcode) && $stable(hex_word)));

    // R4
    single_press_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

    // R5
    done_needs_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(press));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R6
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(opnd_a) && $stable(opnd_b) && $stable(opcode) && $stable(hex_word)));

endmodule

bind stage_loader stage_loader_chk #(
    .SW_W (SW_W),
    .OP_W (OP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .press    (press),
    .done     (done),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .opcode   (opcode),
    .hex_word (hex_word)
);

// File: tb/stage_loader_tb.sv
module stage_loader_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw = '0;
    logic        btn = 1'b0;
    logic [31:0] opnd_a, opnd_b;
    logic [1:0]  opcode;
    logic [15:0] hex_word;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stage_loader dut_i (
        .clk(clk), .rst_n(rst_n), .sw(sw), .btn(btn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opcode(opcode),
        .hex_word(hex_word), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at negedge; outputs are sampled at negedge after the capturing posedge
    task automatic press_hold(input logic [15:0] val, input int hold);
        @(negedge clk);
        sw  = val;
        btn = 1'b1;
        @(negedge clk);
        for (int i = 1; i < hold; i++) @(negedge clk);
        btn = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R7 opnd_a", opnd_a, 32'h0);
        check("R7 opnd_b", opnd_b, 32'h0);
        check("R7 opcode", {30'h0, opcode}, 32'h0);
        check("R7 hex_word", {16'h0, hex_word}, 32'h0);
        check("R7 done", {31'h0, done}, 32'h0);
    endtask

    task automatic t_full_load();
        // first capture visible one edge after btn rises
        @(negedge clk);
        sw = 16'h3F99; btn = 1'b1;
        @(negedge clk);
        check("R2 hex after A hi", {16'h0, hex_word}, 32'h3F99);
        check("R1 A hi", opnd_a, 32'h3F99_0000);
        // held for several cycles with switch change: no further advance
        sw = 16'h5555;
        repeat (4) @(negedge clk);
        check("R4 held hex", {16'h0, hex_word}, 32'h3F99);
        check("R4 held A", opnd_a, 32'h3F99_0000);
        btn = 1'b0;
        @(negedge clk);
        sw = 16'hABCD;
        repeat (3) @(negedge clk);
        check("R8 no press A", opnd_a, 32'h3F99_0000);
        check("R8 no press hex", {16'h0, hex_word}, 32'h3F99);
        press_hold(16'h999A, 1);
        check("R1 A lo", opnd_a, 32'h3F99_999A);
        check("R2 hex A lo", {16'h0, hex_word}, 32'h999A);
        press_hold(16'hFFFE, 2);
        check("R3 opcode mul", {30'h0, opcode}, 32'h2);
        check("R2 hex opcode", {16'h0, hex_word}, 32'h0002);
        check("R5 done low", {31'h0, done}, 32'h0);
        press_hold(16'h4000, 1);
        check("R1 B hi", opnd_b, 32'h4000_0000);
        check("R5 done low B hi", {31'h0, done}, 32'h0);
        @(negedge clk);
        sw = 16'h0001; btn = 1'b1;
        @(negedge clk);
        check("R1 B lo", opnd_b, 32'h4000_0001);
        check("R5 done rises", {31'h0, done}, 32'h1);
        btn = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold_ignores();
        press_hold(16'h1234, 1);
        press_hold(16'h5678, 3);
        check("R6 A frozen", opnd_a, 32'h3F99_999A);
        check("R6 B frozen", opnd_b, 32'h4000_0001);
        check("R6 op frozen", {30'h0, opcode}, 32'h2);
        check("R6 hex frozen", {16'h0, hex_word}, 32'h0001);
        check("R6 done stays", {31'h0, done}, 32'h1);
    endtask

    task automatic t_reset_midway();
        do_reset();
        press_hold(16'hC0DE, 1);
        press_hold(16'hBEEF, 1);
        do_reset();
        @(negedge clk);
        check("R7 mid A", opnd_a, 32'h0);
        check("R7 mid hex", {16'h0, hex_word}, 32'h0);
        press_hold(16'h1111, 1);
        check("R7 restart at A hi", opnd_a, 32'h1111_0000);
        press_hold(16'h2222, 1);
        press_hold(16'h0007, 1);
        check("R3 opcode div upper ignored", {30'h0, opcode}, 32'h3);
        check("R2 opcode zero-extended", {16'h0, hex_word}, 32'h0003);
        press_hold(16'h3333, 1);
        check("R5 not done after 4", {31'h0, done}, 32'h0);
        press_hold(16'h4444, 1);
        check("R1 second A", opnd_a, 32'h1111_2222);
        check("R1 second B", opnd_b, 32'h3333_4444);
        check("R5 done after 5", {31'h0, done}, 32'h1);
    endtask

    initial begin
        t_reset_state();
        t_full_load();
        t_hold_ignores();
        t_reset_midway();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule